// File: doc/BRIEF.md
# Local Memory Shared-Block Flag Tracker

This block sits next to the local memory of one processing node. The memory is divided into cache-block-sized regions, and the block holds one flag bit per region. The flag records whether some other node in the same cluster has made a coherent access to that region since the local cache controller last touched it.

Two request streams drive the flags. Coherent reads and writes that arrive from other nodes in the cluster set the flag of the region they address. Cacheable accesses from the node's own cache controller clear it. For every local access, the block also makes a combinational decision on whether the access must go out on the external data bus so that the other caches can snoop it. Only coherent data accesses to a flagged region go out. Instruction fetches, non-cacheable accesses and accesses to unflagged regions stay inside the node.

Top module: `shared_flag_tracker`

## Requirements
- R1: There is one flag per region of 2**OFF_W bytes. The region index is the address with its OFF_W low offset bits dropped. Two addresses that differ only in those offset bits share one flag.
- R2: An asynchronous active-low reset clears every flag. A coherent local data access made right after reset is kept internal.
- R3: A remote request with kind coherent read (2'b01) or coherent write (2'b10) sets the flag of its region. The new value is seen from the next cycle on.
- R4: A local request with kind instruction fetch (2'b00), coherent read (2'b01) or coherent write (2'b10) clears the flag of its region from the next cycle on.
- R5: Kind non-cacheable (2'b11), on either stream, leaves every flag unchanged. A remote instruction fetch (2'b00) also leaves every flag unchanged.
- R6: ext_bus_req is high in the same cycle as a local request exactly when that request is a coherent read or a coherent write and its region's flag was set at the start of the cycle.
- R7: A local instruction fetch never raises ext_bus_req, whatever the state of the flag.
- R8: When a remote set and a local clear target the same region in the same cycle, the flag ends up set.
- R9: A remote set and a local clear on different regions in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| loc_valid | input | 1 | Local cache controller request present |
| loc_kind | input | 2 | Local kind: 00 fetch, 01 coherent read, 10 coherent write, 11 non-cacheable |
| loc_addr | input | ADDR_W | Local request byte address |
| rem_valid | input | 1 | Remote in-cluster request present |
| rem_kind | input | 2 | Remote kind, same encoding as loc_kind |
| rem_addr | input | ADDR_W | Remote request byte address |
| ext_bus_req | output | 1 | Current local access must use the external data bus |

## Verification
On every cycle, the assertions check the following. A bus request is only ever raised for a coherent data access to a flagged region, and never for a fetch. A remote coherent access leaves its region flagged, even when a local clear hits the same region. A local clear with no competing set leaves the region unflagged. Cycles carrying only non-cacheable traffic or remote fetches leave the whole flag array unchanged. Only the bench scenarios can show the rest: the flag is cleared at reset, addresses with different offsets alias to one flag, and the routing decision follows the full history of each region across interleaved streams.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'b00,
    ACC_COH_RD = 2'b01,
    ACC_COH_WR = 2'b10,
    ACC_NONC   = 2'b11
  } acc_kind_e;

  // coherent data access: may need to be seen by other caches
  function automatic logic is_coh_data(input logic [1:0] kind);
    return (kind == ACC_COH_RD) || (kind == ACC_COH_WR);
  endfunction

  // local cacheable access releases the region back to private use
  function automatic logic local_clears(input logic [1:0] kind);
    return kind != ACC_NONC;
  endfunction

  // remote coherent data access marks the region as shared
  function automatic logic remote_sets(input logic [1:0] kind);
    return is_coh_data(kind);
  endfunction

endpackage

// File: rtl/sft_reset_sync.sv
module sft_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sft_block_decode.sv
module sft_block_decode #(
  parameter int ADDR_W = 14,
  parameter int OFF_W  = 5,
  localparam int IDX_W  = ADDR_W - OFF_W,
  localparam int NUM_BLK = 1 << IDX_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               enable,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_BLK-1:0] onehot
);

  logic [ADDR_W-1:0] shifted;

  always_comb begin
    shifted = addr >> OFF_W;
    idx     = shifted[IDX_W-1:0];
  end

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_sel
    assign onehot[b] = enable && (idx == IDX_W'(b));
  end

endmodule

// File: rtl/sft_flag_array.sv
module sft_flag_array #(
  parameter int NUM_BLK = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BLK-1:0] set_vec,
  input  logic [NUM_BLK-1:0] clr_vec,
  output logic [NUM_BLK-1:0] flags_q
);

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_bit
    logic flag_d;
    logic flag_en;

    // set has priority over clear for the same region
    always_comb begin
      flag_en = set_vec[b] | clr_vec[b];
      flag_d  = set_vec[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[b] <= 1'b0;
      end else if (flag_en) begin
        flags_q[b] <= flag_d;
      end
    end
  end

endmodule

// File: rtl/sft_route.sv
module sft_route (
  input  logic       loc_valid,
  input  logic [1:0] loc_kind,
  input  logic       flag_bit,
  output logic       ext_bus_req
);
  import sft_pkg::*;

  always_comb begin
    ext_bus_req = 1'b0;
    if (loc_valid) begin
      unique case (loc_kind)
        ACC_COH_RD, ACC_COH_WR: ext_bus_req = flag_bit;
        ACC_FETCH:              ext_bus_req = 1'b0;  // code is never modified
        default:                ext_bus_req = 1'b0;  // non-cacheable
      endcase
    end
  end

endmodule

// File: rtl/shared_flag_tracker.sv
module shared_flag_tracker #(
  parameter int ADDR_W = 14,
  parameter int OFF_W  = 5,
  localparam int IDX_W   = ADDR_W - OFF_W,
  localparam int NUM_BLK = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_valid,
  input  logic [1:0]        loc_kind,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              rem_valid,
  input  logic [1:0]        rem_kind,
  input  logic [ADDR_W-1:0] rem_addr,
  output logic              ext_bus_req
);
  import sft_pkg::*;

  logic               rst_sync_n;
  logic               loc_clr_en;
  logic               rem_set_en;
  logic [IDX_W-1:0]   loc_idx;
  logic [IDX_W-1:0]   rem_idx;
  logic [NUM_BLK-1:0] clr_vec;
  logic [NUM_BLK-1:0] set_vec;
  logic [NUM_BLK-1:0] flags_q;
  logic               loc_flag;

  sft_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    loc_clr_en = loc_valid && local_clears(loc_kind);
    rem_set_en = rem_valid && remote_sets(rem_kind);
  end

  sft_block_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_loc_dec (
    .addr   (loc_addr),
    .enable (loc_clr_en),
    .idx    (loc_idx),
    .onehot (clr_vec)
  );

  sft_block_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_rem_dec (
    .addr   (rem_addr),
    .enable (rem_set_en),
    .idx    (rem_idx),
    .onehot (set_vec)
  );

  sft_flag_array #(.NUM_BLK(NUM_BLK)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags_q (flags_q)
  );

  assign loc_flag = flags_q[loc_idx];

  sft_route u_route (
    .loc_valid   (loc_valid),
    .loc_kind    (loc_kind),
    .flag_bit    (loc_flag),
    .ext_bus_req (ext_bus_req)
  );

endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
  parameter int ADDR_W = 14,
  parameter int OFF_W  = 5,
  localparam int IDX_W   = ADDR_W - OFF_W,
  localparam int NUM_BLK = 1 << IDX_W
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               loc_valid,
  input logic [1:0]         loc_kind,
  input logic [ADDR_W-1:0]  loc_addr,
  input logic               rem_valid,
  input logic [1:0]         rem_kind,
  input logic [ADDR_W-1:0]  rem_addr,
  input logic [NUM_BLK-1:0] flags_q,
  input logic               ext_bus_req
);

  logic [ADDR_W-1:0] la_sh;
  logic [ADDR_W-1:0] ra_sh;
  logic [IDX_W-1:0]  li;
  logic [IDX_W-1:0]  ri;
  logic              l_coh;
  logic              l_clr;
  logic              r_hit;
  logic              quiet;

  always_comb begin
    la_sh = loc_addr >> OFF_W;
    ra_sh = rem_addr >> OFF_W;
    li    = la_sh[IDX_W-1:0];
    ri    = ra_sh[IDX_W-1:0];
    l_coh = loc_valid && (loc_kind == 2'b01 || loc_kind == 2'b10);
    l_clr = loc_valid && (loc_kind != 2'b11);
    r_hit = rem_valid && (rem_kind == 2'b01 || rem_kind == 2'b10);
    quiet = (!loc_valid || loc_kind == 2'b11) &&
            (!rem_valid || rem_kind == 2'b11 || rem_kind == 2'b00);
  end

  p_ext_cause_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_bus_req |-> (l_coh && flags_q[li]));

  p_ext_when_flag_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (l_coh && flags_q[li]) |-> ext_bus_req);

  p_fetch_internal_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (loc_valid && loc_kind == 2'b00) |-> !ext_bus_req);

  p_remote_set_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    r_hit |=> flags_q[$past(ri)]);

  p_collision_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (r_hit && l_clr && li == ri) |=> flags_q[$past(li)]);

  p_local_clear_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (l_clr && !(r_hit && ri == li)) |=> !flags_q[$past(li)]);

  p_quiet_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    quiet |=> $stable(flags_q));

endmodule

bind shared_flag_tracker sft_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .loc_valid   (loc_valid),
  .loc_kind    (loc_kind),
  .loc_addr    (loc_addr),
  .rem_valid   (rem_valid),
  .rem_kind    (rem_kind),
  .rem_addr    (rem_addr),
  .flags_q     (flags_q),
  .ext_bus_req (ext_bus_req)
);

// File: tb/shared_flag_tracker_test.sv
module shared_flag_tracker_test;

  localparam int AW = 14;

  typedef struct packed {
    logic          lv;
    logic [1:0]    lk;
    logic [AW-1:0] la;
    logic          rv;
    logic [1:0]    rk;
    logic [AW-1:0] ra;
    logic          ex;
    logic [3:0]    req;
  } vec_t;

  // kinds: 0 fetch, 1 coherent read, 2 coherent write, 3 non-cacheable
  // regions: A=0x0040 (alias 0x005F), B=0x0100, C=0x3FE0
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 14'h0040, 1'b0, 2'd0, 14'h0000, 1'b0, 4'd2}, // R2 after reset
    '{1'b0, 2'd0, 14'h0000, 1'b1, 2'd2, 14'h0040, 1'b0, 4'd3}, // R3 remote write A
    '{1'b1, 2'd1, 14'h005F, 1'b0, 2'd0, 14'h0000, 1'b1, 4'd1}, // R1 alias hits A
    '{1'b1, 2'd2, 14'h0040, 1'b0, 2'd0, 14'h0000, 1'b0, 4'd4}, // R4 cleared by read
    '{1'b0, 2'd0, 14'h0000, 1'b1, 2'd1, 14'h0100, 1'b0, 4'd3}, // R3 remote read B
    '{1'b1, 2'd0, 14'h0100, 1'b0, 2'd0, 14'h0000, 1'b0, 4'd7}, // R7 fetch internal
    '{1'b1, 2'd1, 14'h0100, 1'b0, 2'd0, 14'h0000, 1'b0, 4'd4}, // R4 fetch cleared
    '{1'b0, 2'd0, 14'h0000, 1'b1, 2'd1, 14'h0100, 1'b0, 4'd3}, // R3 set B again
    '{1'b1, 2'd3, 14'h0100, 1'b0, 2'd0, 14'h0000, 1'b0, 4'd6}, // R6 non-cacheable
    '{1'b1, 2'd2, 14'h0100, 1'b1, 2'd3, 14'h3FE0, 1'b1, 4'd5}, // R5 flag kept
    '{1'b1, 2'd1, 14'h3FE0, 1'b0, 2'd0, 14'h0000, 1'b0, 4'd5}, // R5 remote nc no set
    '{1'b0, 2'd0, 14'h0000, 1'b1, 2'd0, 14'h3FE0, 1'b0, 4'd5}, // R5 remote fetch
    '{1'b1, 2'd1, 14'h3FE0, 1'b0, 2'd0, 14'h0000, 1'b0, 4'd5}, // R5 still clear
    '{1'b0, 2'd0, 14'h0000, 1'b1, 2'd2, 14'h3FE0, 1'b0, 4'd3}, // R3 set C
    '{1'b1, 2'd2, 14'h3FE0, 1'b1, 2'd1, 14'h3FE0, 1'b1, 4'd8}, // R8 collision
    '{1'b1, 2'd1, 14'h3FE0, 1'b0, 2'd0, 14'h0000, 1'b1, 4'd8}, // R8 set won
    '{1'b1, 2'd1, 14'h3FE0, 1'b1, 2'd1, 14'h0040, 1'b0, 4'd9}, // R9 split regions
    '{1'b1, 2'd1, 14'h0040, 1'b0, 2'd0, 14'h0000, 1'b1, 4'd9}, // R9 A set
    '{1'b1, 2'd1, 14'h0040, 1'b1, 2'd2, 14'h0100, 1'b0, 4'd9}, // R9 A cleared
    '{1'b1, 2'd2, 14'h0100, 1'b0, 2'd0, 14'h0000, 1'b1, 4'd9}  // R9 B set
  };

  logic          clk;
  logic          rst_n;
  logic          loc_valid;
  logic [1:0]    loc_kind;
  logic [AW-1:0] loc_addr;
  logic          rem_valid;
  logic [1:0]    rem_kind;
  logic [AW-1:0] rem_addr;
  logic          ext_bus_req;

  int checks;
  int errors;
  bit done;

  shared_flag_tracker #(.ADDR_W(AW), .OFF_W(5)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .loc_valid   (loc_valid),
    .loc_kind    (loc_kind),
    .loc_addr    (loc_addr),
    .rem_valid   (rem_valid),
    .rem_kind    (rem_kind),
    .rem_addr    (rem_addr),
    .ext_bus_req (ext_bus_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input logic exp, input int req);
    checks++;
    if (ext_bus_req !== exp) begin
      errors++;
      $display("FAIL R%0d ext_bus_req actual %b expected %b", req, ext_bus_req, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns later, before the rising edge
  task automatic apply(input logic lv, input logic [1:0] lk, input logic [AW-1:0] la,
                       input logic rv, input logic [1:0] rk, input logic [AW-1:0] ra,
                       input logic ex, input int req);
    @(negedge clk);
    loc_valid = lv; loc_kind = lk; loc_addr = la;
    rem_valid = rv; rem_kind = rk; rem_addr = ra;
    #1;
    check(ex, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    loc_valid = 1'b0; loc_kind = 2'd0; loc_addr = '0;
    rem_valid = 1'b0; rem_kind = 2'd0; rem_addr = '0;
    do_reset();
    #1;
    check(1'b0, 2); // R2 idle after reset

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].lv, VEC[i].lk, VEC[i].la, VEC[i].rv, VEC[i].rk, VEC[i].ra,
            VEC[i].ex, int'(VEC[i].req));
    end

    // R2: flag several regions, reset, confirm they are all clear
    apply(1'b0, 2'd0, 14'h0000, 1'b1, 2'd2, 14'h0040, 1'b0, 3);
    apply(1'b0, 2'd0, 14'h0000, 1'b1, 2'd1, 14'h3FE0, 1'b0, 3);
    apply(1'b0, 2'd0, 14'h0000, 1'b0, 2'd0, 14'h0000, 1'b0, 3);
    @(negedge clk);
    do_reset();
    apply(1'b1, 2'd1, 14'h0040, 1'b0, 2'd0, 14'h0000, 1'b0, 2);
    apply(1'b1, 2'd2, 14'h3FE0, 1'b0, 2'd0, 14'h0000, 1'b0, 2);

    // R7: flagged region, fetch stays internal, then flag is gone (R4)
    apply(1'b0, 2'd0, 14'h0000, 1'b1, 2'd1, 14'h1000, 1'b0, 3);
    apply(1'b1, 2'd0, 14'h1000, 1'b0, 2'd0, 14'h0000, 1'b0, 7);
    apply(1'b1, 2'd2, 14'h101F, 1'b0, 2'd0, 14'h0000, 1'b0, 4);

    // R1: neighbouring region does not alias
    apply(1'b0, 2'd0, 14'h0000, 1'b1, 2'd2, 14'h1000, 1'b0, 3);
    apply(1'b1, 2'd1, 14'h1020, 1'b0, 2'd0, 14'h0000, 1'b0, 1);
    apply(1'b1, 2'd1, 14'h1000, 1'b0, 2'd0, 14'h0000, 1'b1, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule